// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block collects 64 interrupt lines and hands the processor two request outputs, a normal interrupt and a fast interrupt. Each line has a one-byte setup register: an enable, a trigger choice (active-high level, rising edge, falling edge or both edges) and a three-bit destination code. Edges are latched until software clears them by writing ones into a status word. Level lines show their synchronized input directly.

Two priority registers, one per output, report the number of the winning line. Each also holds a bit that switches arbitration from fixed order to a rotating order. When nothing is pending the winner field reads 63. Software tells that case apart from a real request on line 63 by reading bit 31 of the upper status word. Destination codes 2 to 7 are stored and read back, but they drive neither output.

Top module: `rot_intc`

## Requirements
- R1: After reset every setup byte reads 0x00: disabled, level mode, destination 0. Both rotation bits read 0, irq_out and fiq_out are low, and both winner fields read 63.
- R2: The setup byte of line n sits at byte address 0x40+n, which is byte lane n%4 of word 0x40+4*(n/4). Its fields are bit 3 enable, bit 5 rising edge, bit 6 falling edge and bits 2:0 destination. All eight bits read back as written.
- R3: With bit 5 set, a 0-to-1 change of the synchronized input latches the line pending. With bit 6 set, a 1-to-0 change latches it. With both bits set, either change latches it. The latch holds until it is cleared.
- R4: Writing a 1 to bit n%32 of the status word at 0x80 (lines 0-31) or 0x84 (lines 32-63) clears that line's latch, and a 0 bit has no effect. When an edge arrives in the same cycle as the clear, the latch stays set.
- R5: With bits 5 and 6 both clear, a line is pending exactly while its synchronized input is high. Status writes do not change this.
- R6: A status bit shows the line's pending state whether or not the line is enabled.
- R7: A line whose bit 3 is clear never raises an output and never wins.
- R8: irq_out is high exactly when some enabled, pending line has destination 0, and fiq_out the same for destination 1. Destinations 2-7 raise neither output.
- R9: Bits 5:0 of the register at 0x20 (normal output) and at 0x24 (fast output) give the winning line, or 63 when nothing qualifies. A real request on line 63 also shows as bit 31 of word 0x84.
- R10: With bit 6 of a priority register clear, the lowest-numbered qualifying line wins.
- R11: With bit 6 set, the search starts at the line after the last acknowledged line and wraps around. The last acknowledged line is the highest bit set in the most recent status write with any bit set, and it is 63 after reset.
- R12: Each input passes through a two-stage synchronizer. A level line raises its output at the second rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 64 | Raw interrupt lines |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The bench targets a clear and a new edge landing in the same cycle. A design that lets the clear win loses that interrupt silently. It checks that a level line ignores status writes, and that an edge latch survives masking while its status bit stays visible. It checks that the winner field reads 63 both when idle and when line 63 really requests, and that only status bit 31 tells the two apart. For rotation, it checks that the pointer follows the highest bit of the last acknowledge and that the search wraps past 63. An off-by-one in the start point or the wrap gives the wrong winner.

// File: rtl/rot_intc_pkg.sv
package rot_intc_pkg;
  // setup byte fields
  localparam int CB_EN   = 3;
  localparam int CB_RISE = 5;
  localparam int CB_FALL = 6;
  localparam int DEST_W  = 3;
  localparam logic [DEST_W-1:0] DEST_IRQ = 3'd0;
  localparam logic [DEST_W-1:0] DEST_FIQ = 3'd1;

  // bus and register map
  localparam int BUS_W        = 32;
  localparam int LANES        = BUS_W / 8;
  localparam int PRIO_ROT_BIT = 6;
  localparam int A_PRIO_IRQ   = 'h20;
  localparam int A_PRIO_FIQ   = 'h24;
  localparam int A_CTRL_BASE  = 'h40;
  localparam int A_STAT_BASE  = 'h80;

  typedef logic [7:0] setup_t;

  function automatic logic cb_enabled(input setup_t b);
    return b[CB_EN];
  endfunction

  function automatic logic [DEST_W-1:0] cb_dest(input setup_t b);
    return b[DEST_W-1:0];
  endfunction

  function automatic logic cb_rise(input setup_t b);
    return b[CB_RISE];
  endfunction

  function automatic logic cb_fall(input setup_t b);
    return b[CB_FALL];
  endfunction
endpackage

// File: rtl/rot_intc_src_bank.sv
module rot_intc_src_bank #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] rise_en,
  input  logic [NSRC-1:0] fall_en,
  input  logic [NSRC-1:0] ack,
  output logic [NSRC-1:0] pending
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic s1, s2, s3, lat, evt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= src_in[i];
        s2 <= s1;
        s3 <= s2;
      end
    end

    // edge event seen on the synchronized line
    assign evt = (rise_en[i] & s2 & ~s3) | (fall_en[i] & ~s2 & s3);

    // set beats clear so an edge in the clearing cycle is kept
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat <= 1'b0;
      else if (evt)    lat <= 1'b1;
      else if (ack[i]) lat <= 1'b0;
    end

    assign pending[i] = (rise_en[i] | fall_en[i]) ? lat : s2;

    a_r3_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> lat);
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !evt) |=> !lat);
  end
endmodule

// File: rtl/rot_intc_arbiter.sv
module rot_intc_arbiter #(
  parameter int NSRC = 64,
  parameter int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            rotate,
  input  logic [IDXW-1:0] last,
  output logic            any,
  output logic [IDXW-1:0] win
);
  localparam logic [IDXW-1:0] IDLE_IDX = IDXW'(NSRC - 1);

  logic [IDXW-1:0] start;
  logic [IDXW:0]   hit;

  // first requesting index at or after st, wrapping; top bit flags a find
  function automatic logic [IDXW:0] scan(input logic [NSRC-1:0] r,
                                         input logic [IDXW-1:0] st);
    logic [IDXW:0] res;
    res = {1'b0, IDLE_IDX};
    for (int k = NSRC - 1; k >= 0; k--) begin
      int p;
      p = int'(st) + k;
      if (p >= NSRC) p = p - NSRC;
      if (r[IDXW'(p)]) res = {1'b1, IDXW'(p)};
    end
    return res;
  endfunction

  assign start = !rotate ? '0 : ((last == IDLE_IDX) ? '0 : last + 1'b1);
  assign hit   = scan(req, start);
  assign any   = hit[IDXW];
  assign win   = hit[IDXW-1:0];

  a_r9_winner_requests: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[win]);
  a_r9_idle_reads_63: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (win == IDLE_IDX));
  a_r10_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (any && !rotate) |-> ((req & ~({NSRC{1'b1}} << win)) == '0));
endmodule

// File: rtl/rot_intc_regs.sv
module rot_intc_regs
  import rot_intc_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int ADDR_W = 8,
  parameter int IDXW   = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [LANES-1:0]      bus_be,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic [NSRC-1:0]       pending_i,
  input  logic [1:0][IDXW-1:0]  win_i,
  output logic [NSRC-1:0][7:0]  ctrl_o,
  output logic [1:0]            rot_o,
  output logic [NSRC-1:0]       ack_o,
  output logic [IDXW-1:0]       last_o
);
  localparam int WA_W  = ADDR_W - 2;
  localparam int NCW   = NSRC / LANES;
  localparam int NSW   = NSRC / BUS_W;
  localparam logic [WA_W-1:0] WA_PI = WA_W'(A_PRIO_IRQ / 4);
  localparam logic [WA_W-1:0] WA_PF = WA_W'(A_PRIO_FIQ / 4);
  localparam int WA_CB = A_CTRL_BASE / 4;
  localparam int WA_SB = A_STAT_BASE / 4;

  logic [WA_W-1:0] wa;
  logic            unused_addr_lsb;

  assign wa              = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];

  function automatic logic [IDXW-1:0] top_idx(input logic [NSRC-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (v[i]) r = IDXW'(i);
    return r;
  endfunction

  // setup bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '0;
    end else if (bus_wr) begin
      for (int k = 0; k < NCW; k++)
        for (int b = 0; b < LANES; b++)
          if (wa == WA_W'(WA_CB + k) && bus_be[b])
            ctrl_o[LANES*k+b] <= bus_wdata[8*b +: 8];
    end
  end

  // rotation enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_o <= '0;
    end else if (bus_wr && bus_be[0]) begin
      if (wa == WA_PI) rot_o[0] <= bus_wdata[PRIO_ROT_BIT];
      if (wa == WA_PF) rot_o[1] <= bus_wdata[PRIO_ROT_BIT];
    end
  end

  // write-one-to-clear decode
  always_comb begin
    ack_o = '0;
    for (int w = 0; w < NSW; w++)
      for (int i = 0; i < BUS_W; i++)
        if (bus_wr && wa == WA_W'(WA_SB + w) && bus_be[i/8] && bus_wdata[i])
          ack_o[BUS_W*w+i] = 1'b1;
  end

  // last acknowledged line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_o <= IDXW'(NSRC - 1);
    else if (|ack_o) last_o <= top_idx(ack_o);
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (wa == WA_PI) begin
      bus_rdata[IDXW-1:0]    = win_i[0];
      bus_rdata[PRIO_ROT_BIT] = rot_o[0];
    end
    if (wa == WA_PF) begin
      bus_rdata[IDXW-1:0]    = win_i[1];
      bus_rdata[PRIO_ROT_BIT] = rot_o[1];
    end
    for (int k = 0; k < NCW; k++)
      if (wa == WA_W'(WA_CB + k)) bus_rdata = ctrl_o[LANES*k+LANES-1 -: LANES];
    for (int w = 0; w < NSW; w++)
      if (wa == WA_W'(WA_SB + w)) bus_rdata = pending_i[BUS_W*w +: BUS_W];
  end

  a_r11_ptr_highest_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_o) |=> (($past(ack_o) >> last_o) == NSRC'(1)));
endmodule

// File: rtl/rot_intc.sv
module rot_intc
  import rot_intc_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam int IDXW = $clog2(NSRC);

  logic [NSRC-1:0][7:0] ctrl;
  logic [1:0]           rot;
  logic [NSRC-1:0]      ack, pending, rise_en, fall_en;
  logic [IDXW-1:0]      last;
  logic [1:0][NSRC-1:0] req;
  logic [1:0][IDXW-1:0] win;
  logic [1:0]           any;

  rot_intc_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pending_i(pending), .win_i(win), .ctrl_o(ctrl), .rot_o(rot),
    .ack_o(ack), .last_o(last)
  );

  rot_intc_src_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .rise_en(rise_en),
    .fall_en(fall_en), .ack(ack), .pending(pending)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_dec
    logic qual;
    logic unused_bits;
    assign rise_en[i]  = cb_rise(ctrl[i]);
    assign fall_en[i]  = cb_fall(ctrl[i]);
    assign qual        = pending[i] & cb_enabled(ctrl[i]);
    assign req[0][i]   = qual & (cb_dest(ctrl[i]) == DEST_IRQ);
    assign req[1][i]   = qual & (cb_dest(ctrl[i]) == DEST_FIQ);
    assign unused_bits = ctrl[i][7] ^ ctrl[i][4];
  end

  for (genvar d = 0; d < 2; d++) begin : g_arb
    rot_intc_arbiter #(.NSRC(NSRC), .IDXW(IDXW)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req[d]), .rotate(rot[d]),
      .last(last), .any(any[d]), .win(win[d])
    );
  end

  assign irq_out = any[0];
  assign fiq_out = any[1];

  a_r7_irq_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ctrl[win[0]][CB_EN]);
  a_r7_fiq_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out |-> ctrl[win[1]][CB_EN]);
  a_r8_winner_dest_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (ctrl[win[0]][2:0] == DEST_IRQ && pending[win[0]]));
  a_r8_winner_dest_fiq: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out |-> (ctrl[win[1]][2:0] == DEST_FIQ && pending[win[1]]));
endmodule

// File: tb/rot_intc_tb.sv
module rot_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_in = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_ctrl [64];
  bit         m_lat  [64];
  bit         m_in   [64];
  bit         m_rot  [2];
  int         m_ptr;

  always #5 clk = ~clk;

  rot_intc u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_pend(int n);
    if (m_ctrl[n][5] || m_ctrl[n][6]) return m_lat[n];
    return m_in[n];
  endfunction

  function automatic bit exp_req(int n, int d);
    return exp_pend(n) && m_ctrl[n][3] && (int'(m_ctrl[n][2:0]) == d);
  endfunction

  function automatic int exp_win(int d);
    int st;
    st = m_rot[d] ? (m_ptr + 1) % 64 : 0;
    for (int k = 0; k < 64; k++)
      if (exp_req((st + k) % 64, d)) return (st + k) % 64;
    return 63;
  endfunction

  function automatic bit exp_any(int d);
    for (int n = 0; n < 64; n++)
      if (exp_req(n, d)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_stat(int w);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = exp_pend(32 * w + i);
    return v;
  endfunction

  task automatic bus_write(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic write_ctrl(int n, logic [7:0] b);
    m_ctrl[n] = b;
    bus_write(8'(32'h40 + (n / 4) * 4), 4'(1 << (n % 4)), 32'(b) << (8 * (n % 4)));
  endtask

  task automatic ack_word(int w, logic [31:0] d);
    for (int i = 0; i < 32; i++)
      if (d[i]) begin
        m_lat[32 * w + i] = 1'b0;
        m_ptr = 32 * w + i;
      end
    bus_write(8'(32'h80 + 4 * w), 4'hF, d);
  endtask

  task automatic set_rot(int d, bit v);
    m_rot[d] = v;
    bus_write(d == 1 ? 8'h24 : 8'h20, 4'h1, 32'(v) << 6);
  endtask

  task automatic apply_inputs(logic [63:0] nv);
    for (int i = 0; i < 64; i++)
      if (nv[i] != m_in[i]) begin
        if ((nv[i] && m_ctrl[i][5]) || (!nv[i] && m_ctrl[i][6])) m_lat[i] = 1'b1;
        m_in[i] = nv[i];
      end
    @(negedge clk);
    src_in = nv;
    repeat (4) @(negedge clk);
  endtask

  task automatic full_check(string tag);
    logic [31:0] d;
    bus_read(8'h80, d); check_eq(tag, "status0", 64'(d), 64'(exp_stat(0)));
    bus_read(8'h84, d); check_eq(tag, "status1", 64'(d), 64'(exp_stat(1)));
    bus_read(8'h20, d); check_eq(tag, "irq winner", 64'(d[5:0]), 64'(exp_win(0)));
    bus_read(8'h24, d); check_eq(tag, "fiq winner", 64'(d[5:0]), 64'(exp_win(1)));
    check_eq(tag, "irq_out", 64'(irq_out), 64'(exp_any(0)));
    check_eq(tag, "fiq_out", 64'(fiq_out), 64'(exp_any(1)));
  endtask

  task automatic quiesce();
    apply_inputs('0);
    ack_word(0, 32'hFFFF_FFFF);
    ack_word(1, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v;
    for (int i = 0; i < 64; i++) begin
      m_ctrl[i] = '0; m_lat[i] = 1'b0; m_in[i] = 1'b0;
    end
    m_rot[0] = 1'b0; m_rot[1] = 1'b0; m_ptr = 63;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check_eq("R1", "irq_out", 64'(irq_out), 64'd0);
    check_eq("R1", "fiq_out", 64'(fiq_out), 64'd0);
    bus_read(8'h40, d); check_eq("R1", "ctrl word", 64'(d), 64'd0);
    bus_read(8'h7C, d); check_eq("R1", "ctrl last word", 64'(d), 64'd0);
    bus_read(8'h20, d); check_eq("R1", "irq prio reg", 64'(d), 64'd63);
    bus_read(8'h24, d); check_eq("R1", "fiq prio reg", 64'(d), 64'd63);

    // R2 layout: line 5 = lane 1 of word 0x44
    write_ctrl(5, 8'h6A);
    bus_read(8'h44, d); check_eq("R2", "ctrl readback", 64'(d), 64'h6A00);
    write_ctrl(5, 8'h00);

    // R5 level line
    write_ctrl(10, 8'h08);
    v = '0; v[10] = 1'b1; apply_inputs(v);
    check_eq("R5", "irq high", 64'(irq_out), 64'd1);
    bus_read(8'h20, d); check_eq("R5", "winner", 64'(d[5:0]), 64'd10);
    ack_word(0, 32'h400);
    bus_read(8'h80, d); check_eq("R5", "level ignores ack", 64'(d[10]), 64'd1);
    apply_inputs('0);
    check_eq("R5", "irq low", 64'(irq_out), 64'd0);

    // R3/R4 rising latch and clear
    write_ctrl(12, 8'h28);
    v = '0; v[12] = 1'b1; apply_inputs(v);
    apply_inputs('0);
    bus_read(8'h80, d); check_eq("R3", "rising latched", 64'(d[12]), 64'd1);
    ack_word(0, 32'h0000_0000);
    bus_read(8'h80, d); check_eq("R4", "zero write keeps", 64'(d[12]), 64'd1);
    ack_word(0, 32'h0000_1000);
    bus_read(8'h80, d); check_eq("R4", "one write clears", 64'(d[12]), 64'd0);

    // R3/R8 falling latch to fast output
    write_ctrl(40, 8'h49);
    v = '0; v[40] = 1'b1; apply_inputs(v);
    bus_read(8'h84, d); check_eq("R3", "no latch on rise", 64'(d[8]), 64'd0);
    apply_inputs('0);
    check_eq("R8", "fiq high", 64'(fiq_out), 64'd1);
    check_eq("R8", "irq stays low", 64'(irq_out), 64'd0);
    bus_read(8'h24, d); check_eq("R8", "fiq winner", 64'(d[5:0]), 64'd40);
    // R7 masking with R6 status still shown
    write_ctrl(40, 8'h41);
    check_eq("R7", "masked fiq low", 64'(fiq_out), 64'd0);
    bus_read(8'h24, d); check_eq("R7", "masked no win", 64'(d[5:0]), 64'd63);
    bus_read(8'h84, d); check_eq("R6", "status while masked", 64'(d[8]), 64'd1);
    write_ctrl(40, 8'h4B);
    check_eq("R8", "aux dest fiq", 64'(fiq_out), 64'd0);
    check_eq("R8", "aux dest irq", 64'(irq_out), 64'd0);
    ack_word(1, 32'h100);

    // R9 line 63 versus idle
    bus_read(8'h84, d); check_eq("R9", "idle bit31", 64'(d[31]), 64'd0);
    write_ctrl(63, 8'h08);
    v = '0; v[63] = 1'b1; apply_inputs(v);
    bus_read(8'h20, d); check_eq("R9", "winner 63", 64'(d[5:0]), 64'd63);
    bus_read(8'h84, d); check_eq("R9", "real bit31", 64'(d[31]), 64'd1);
    apply_inputs('0);

    // R10 fixed and R11 rotating
    write_ctrl(20, 8'h08); write_ctrl(30, 8'h08);
    v = '0; v[20] = 1'b1; v[30] = 1'b1; apply_inputs(v);
    bus_read(8'h20, d); check_eq("R10", "lowest wins", 64'(d[5:0]), 64'd20);
    set_rot(0, 1'b1);
    bus_read(8'h20, d); check_eq("R11", "rot bit readback", 64'(d[6]), 64'd1);
    ack_word(0, 32'h0010_0000);
    bus_read(8'h20, d); check_eq("R11", "after ack 20", 64'(d[5:0]), 64'd30);
    ack_word(0, 32'h4000_0001);
    bus_read(8'h20, d); check_eq("R11", "wrap after 30", 64'(d[5:0]), 64'd20);
    set_rot(0, 1'b0);
    quiesce();

    // R4 edge in the clearing cycle
    write_ctrl(2, 8'h28);
    v = '0; v[2] = 1'b1; apply_inputs(v);
    apply_inputs('0);
    @(negedge clk); src_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h80; bus_be = 4'hF; bus_wdata = 32'h4;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
    m_in[2] = 1'b1; m_lat[2] = 1'b1; m_ptr = 2;
    bus_read(8'h80, d); check_eq("R4", "set beats clear", 64'(d[2]), 64'd1);
    quiesce();

    // R12 two-stage latency
    write_ctrl(15, 8'h08);
    @(negedge clk); src_in[15] = 1'b1; m_in[15] = 1'b1;
    @(negedge clk); check_eq("R12", "after one edge", 64'(irq_out), 64'd0);
    @(negedge clk); check_eq("R12", "after two edges", 64'(irq_out), 64'd1);
    quiesce();

    // random phase
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: begin
          logic [7:0] b;
          b = 8'($urandom);
          if ($urandom % 2 == 0) b[2:1] = 2'b00;
          write_ctrl(int'($urandom % 64), b);
        end
        1: apply_inputs({$urandom, $urandom});
        2: ack_word(int'($urandom % 2), $urandom & $urandom);
        3: set_rot(int'($urandom % 2), 1'($urandom));
        default: begin
          v = src_in;
          v[$urandom % 64] = ~v[$urandom % 64];
          apply_inputs(v);
        end
      endcase
      full_check("R3/R5/R8/R9/R10/R11 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule